// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Flow Control

This block turns characters into an asynchronous serial line signal. A single-character holding stage accepts a byte from the write side whenever the transmitter reports ready. The byte moves into the serializer at the next character boundary. The serializer then sends a start bit, 5 to 8 data bits, an optional parity bit and a stop period. The stop period is programmable in sixteenths of a bit. All timing comes from a 16x bit-rate enable pulse supplied from outside, so every bit lasts 16 enable pulses.

Around the serializer sit the pacing controls. A clear-to-send input can hold back a character before it starts, but a character already on the line always finishes. Break commands force the line to space and release it again. A request-to-send output can be dropped automatically one bit time after the transmitter has run dry. Character format, parity and stop length are captured when each character starts, so they apply to that whole character.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, and whenever the transmitter is empty (no character held and none being shifted), `txd` is high (mark). During reset `tx_emt` is 1, `rts` is 0, and `tx_rdy` follows `tx_en`.
- R2: A character is framed as follows, with every bit lasting exactly 16 `tick16` pulses:
  - one low start bit;
  - the data bits, least significant first; `cfg_bits` 0, 1, 2, 3 selects 5, 6, 7, 8 bits, and unused upper data bits are ignored.
- R3: `cfg_par` selects the parity bit, which follows the data bits:
  - 0: parity bit equal to the XOR of the data bits, then XOR `cfg_odd` (`cfg_odd`=1 gives odd parity);
  - 1: forced parity bit equal to `cfg_odd`;
  - 2 or 3: no parity bit, and `cfg_odd` has no effect.
- R4: Stop length in `tick16` pulses is 9+code for codes 0 to 7, plus 8 more when the character has 5 bits. It is 17+code for codes 8 to 15, so code 15 gives exactly two bit times. When another character is held, its start bit follows the stop period with no extra idle time.
- R5: `tx_rdy` is high exactly when `tx_en` is 1 and the holding stage is empty. A write (`wr_valid`) is taken only while `tx_rdy` is high. `tx_emt` is high only when the holding stage and the serializer are both empty.
- R6: With `cfg_cts_en`=1 and `cts`=1, no character starts; any held character waits until `cts` returns to 0. Raising `cts` during a character does not shorten that character.
- R7: A `brk_start` pulse drives `txd` low. If it arrives while idle, the line goes low at once, well inside two bit times. If it arrives while a character is being sent, that character completes first. A held character does not start while a break is active or pending.
- R8: After a `brk_stop` pulse ends a break, `txd` is high for at least 16 `tick16` pulses before the next start bit.
- R9: `rts_set` raises `rts` and `rts_clr` lowers it. With `cfg_rts_auto`=1, `rts` falls on the 16th `tick16` pulse after `tx_emt` rises. With `cfg_rts_auto`=0, `rts` does not fall on its own.
- R10: While `tx_en` is 0, writes are ignored and a held character does not start. It starts once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| tx_en | input | 1 | Transmitter enable |
| cfg_bits | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par | input | 2 | Parity mode (0 normal, 1 forced, 2/3 none) |
| cfg_odd | input | 1 | Odd parity / forced parity level |
| cfg_stop | input | 4 | Stop length code |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cfg_rts_auto | input | 1 | Enable automatic request-to-send drop |
| cts | input | 1 | Clear-to-send, high holds off new characters |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| brk_start | input | 1 | Start-break command pulse |
| brk_stop | input | 1 | Stop-break command pulse |
| rts_set | input | 1 | Raise request-to-send |
| rts_clr | input | 1 | Lower request-to-send |
| txd | output | 1 | Serial data out |
| tx_rdy | output | 1 | Holding stage can accept a character |
| tx_emt | output | 1 | Holding stage and serializer both empty |
| rts | output | 1 | Request-to-send output |

## Verification
Every character length is swept against every parity mode and both parity senses. Each sweep point uses a complementary pair of data bytes, which separates bit-order errors from stuck or swapped bits and makes normal, forced and absent parity give different line bits. A second sweep goes through all sixteen stop codes at 5-bit and 8-bit length. For each point it measures the distance in tick pulses between two back-to-back start edges, so an off-by-one in the stop counter or a missing half-bit extension shows up as a count error. Separate scenarios cover:
- clear-to-send raised before a character and during one;
- breaks requested while idle and while busy;
- automatic and manual request-to-send;
- the disabled transmitter.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int CHAR_MAX = 8;
   localparam int CHAR_MIN = 5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_BRKEND
   } tx_state_t;

   localparam logic [1:0] PAR_NORMAL = 2'd0;
   localparam logic [1:0] PAR_FORCE  = 2'd1;

   // Stop period in oversampling ticks for a given code.
   function automatic logic [5:0] stop_len(input logic [3:0] code,
                                           input logic five,
                                           input int bt);
      int n;
      if (code < 4'd8) n = bt / 2 + 1 + int'(code) + (five ? bt / 2 : 0);
      else             n = bt + 1 + int'(code);
      return 6'(n);
   endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data,
   output logic              ready
);

   assign ready = tx_en && !hold_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else if (wr_valid && ready) begin
         hold_valid <= 1'b1;
         hold_data  <= wr_data;
      end else if (take) begin
         hold_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int BIT_TICKS = 16,
   parameter int CNT_W     = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                tx_en,
   input  logic [1:0]          cfg_bits,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_odd,
   input  logic [3:0]          cfg_stop,
   input  logic                cfg_cts_en,
   input  logic                cts,
   input  logic                hold_valid,
   input  logic [CHAR_MAX-1:0] hold_data,
   input  logic                brk_start,
   input  logic                brk_stop,
   output logic                take,
   output logic                txd,
   output logic                idle
);

   localparam int LEFT_W = $clog2(CHAR_MAX + 1);

   tx_state_t             state;
   logic [CNT_W-1:0]      cnt;
   logic [CHAR_MAX-1:0]   sh;
   logic [LEFT_W-1:0]     left;
   logic                  par_bit, has_par, brk_pend;
   logic [5:0]            stop_q;
   logic                  bit_end, stop_end;
   logic [CHAR_MAX-1:0]   mask;
   logic                  blocked;

   assign mask     = {CHAR_MAX{1'b1}} >> (3 - cfg_bits);
   assign bit_end  = tick && (cnt == CNT_W'(BIT_TICKS - 1));
   assign stop_end = tick && (cnt == CNT_W'(stop_q - 6'd1));
   assign blocked  = cfg_cts_en && cts;
   assign idle     = (state == ST_IDLE);
   assign take     = idle && hold_valid && tx_en && !blocked && !brk_pend;

   always_comb begin
      unique case (state)
         ST_START, ST_BRK: txd = 1'b0;
         ST_DATA:          txd = sh[0];
         ST_PAR:           txd = par_bit;
         default:          txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         left     <= '0;
         par_bit  <= 1'b0;
         has_par  <= 1'b0;
         stop_q   <= 6'd16;
         brk_pend <= 1'b0;
      end else begin
         if (brk_start && state != ST_BRK) brk_pend <= 1'b1;
         if (brk_stop)                     brk_pend <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (brk_pend && !brk_stop) begin
                  state    <= ST_BRK;
                  brk_pend <= 1'b0;
               end else if (take) begin
                  state   <= ST_START;
                  sh      <= hold_data & mask;
                  left    <= LEFT_W'(CHAR_MIN + int'(cfg_bits));
                  has_par <= !cfg_par[1];
                  par_bit <= (cfg_par == PAR_FORCE) ? cfg_odd
                                                    : (^(hold_data & mask)) ^ cfg_odd;
                  stop_q  <= stop_len(cfg_stop, cfg_bits == 2'd0, BIT_TICKS);
               end
            end
            ST_START: if (tick) begin
               cnt <= bit_end ? '0 : cnt + 1'b1;
               if (bit_end) state <= ST_DATA;
            end
            ST_DATA: if (tick) begin
               cnt <= bit_end ? '0 : cnt + 1'b1;
               if (bit_end) begin
                  sh   <= sh >> 1;
                  left <= left - 1'b1;
                  if (left == LEFT_W'(1)) state <= has_par ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: if (tick) begin
               cnt <= bit_end ? '0 : cnt + 1'b1;
               if (bit_end) state <= ST_STOP;
            end
            ST_STOP: if (tick) begin
               cnt <= stop_end ? '0 : cnt + 1'b1;
               if (stop_end) state <= ST_IDLE;
            end
            ST_BRK: begin
               cnt <= '0;
               if (brk_stop) state <= ST_BRKEND;
            end
            ST_BRKEND: if (tick) begin
               cnt <= bit_end ? '0 : cnt + 1'b1;
               if (bit_end) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts #(
   parameter int DELAY_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic auto_en,
   input  logic empty,
   input  logic set_req,
   input  logic clr_req,
   output logic rts
);

   localparam int DW = $clog2(DELAY_TICKS + 1);
   logic [DW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts <= 1'b0;
         cnt <= '0;
      end else if (clr_req) begin
         rts <= 1'b0;
         cnt <= '0;
      end else if (set_req) begin
         rts <= 1'b1;
         cnt <= '0;
      end else if (!empty || !auto_en || !rts) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt == DW'(DELAY_TICKS - 1)) begin
            rts <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
   import uart_tx_pkg::*;
#(
   parameter int BIT_TICKS = 16,
   parameter int RTS_BITS  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       tx_en,
   input  logic [1:0] cfg_bits,
   input  logic [1:0] cfg_par,
   input  logic       cfg_odd,
   input  logic [3:0] cfg_stop,
   input  logic       cfg_cts_en,
   input  logic       cfg_rts_auto,
   input  logic       cts,
   input  logic       wr_valid,
   input  logic [7:0] wr_data,
   input  logic       brk_start,
   input  logic       brk_stop,
   input  logic       rts_set,
   input  logic       rts_clr,
   output logic       txd,
   output logic       tx_rdy,
   output logic       tx_emt,
   output logic       rts
);

   localparam int CNT_W     = $clog2(2 * BIT_TICKS + 1);
   localparam int RTS_TICKS = RTS_BITS * BIT_TICKS;

   if (BIT_TICKS != 16) begin : g_bad_ticks
      $error("uart_tx_top: stop codes are defined for 16 ticks per bit");
   end
   if (RTS_BITS < 1) begin : g_bad_rts
      $error("uart_tx_top: RTS_BITS must be at least 1");
   end

   logic                hold_valid, take, idle;
   logic [CHAR_MAX-1:0] hold_data;

   uart_tx_hold #(.DATA_W(CHAR_MAX)) u_hold (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .take(take),
      .hold_valid(hold_valid), .hold_data(hold_data), .ready(tx_rdy)
   );

   uart_tx_shift #(.BIT_TICKS(BIT_TICKS), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .tx_en(tx_en),
      .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_odd(cfg_odd),
      .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cts(cts),
      .hold_valid(hold_valid), .hold_data(hold_data),
      .brk_start(brk_start), .brk_stop(brk_stop),
      .take(take), .txd(txd), .idle(idle)
   );

   assign tx_emt = idle && !hold_valid;

   uart_tx_rts #(.DELAY_TICKS(RTS_TICKS)) u_rts (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .auto_en(cfg_rts_auto),
      .empty(tx_emt), .set_req(rts_set), .clr_req(rts_clr), .rts(rts)
   );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_valid,
   input logic rts_set,
   input logic rts_clr,
   input logic txd,
   input logic tx_rdy,
   input logic tx_emt,
   input logic rts
);

   p_mark_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_emt |-> txd);

   p_ready_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_emt && tx_en) |-> tx_rdy);

   p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && tx_rdy) |=> !tx_emt);

   p_rts_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rts) |-> ($past(rts_clr) || $past(tx_emt)));

   p_rts_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rts) |-> $past(rts_set));

endmodule

bind uart_tx_top uart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
   .rts_set(rts_set), .rts_clr(rts_clr), .txd(txd), .tx_rdy(tx_rdy),
   .tx_emt(tx_emt), .rts(rts)
);

// File: tb/sim_uart_tx_top.sv
module sim_uart_tx_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       tx_en = 1'b0;
   logic [1:0] cfg_bits = 2'd3;
   logic [1:0] cfg_par = 2'd2;
   logic       cfg_odd = 1'b0;
   logic [3:0] cfg_stop = 4'hF;
   logic       cfg_cts_en = 1'b0;
   logic       cfg_rts_auto = 1'b0;
   logic       cts = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       brk_start = 1'b0;
   logic       brk_stop = 1'b0;
   logic       rts_set = 1'b0;
   logic       rts_clr = 1'b0;
   logic       txd, tx_rdy, tx_emt, rts;

   int checks = 0;
   int errors = 0;
   int tcount = 0;
   int phase = 0;

   always #10 clk = ~clk;

   // Tick generator: one pulse every 4 clocks; tcount = ticks consumed so far.
   always @(negedge clk) begin
      if (tick16) tcount++;
      phase = (phase == 3) ? 0 : phase + 1;
      tick16 = (phase == 0);
   end

   uart_tx_top u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
      .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_odd(cfg_odd),
      .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
      .cts(cts), .wr_valid(wr_valid), .wr_data(wr_data),
      .brk_start(brk_start), .brk_stop(brk_stop),
      .rts_set(rts_set), .rts_clr(rts_clr),
      .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .rts(rts)
   );

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_ticks(input int n);
      int t0;
      t0 = tcount;
      while (tcount < t0 + n) step();
   endtask

   task automatic write_char(input logic [7:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      step();
      wr_valid = 1'b0;
   endtask

   task automatic wait_fall(output int a);
      while (txd !== 1'b0) step();
      a = tcount;
   endtask

   task automatic wait_empty();
      while (tx_emt !== 1'b1) step();
   endtask

   // Frame bits from the requirements: start, data LSB first, optional parity.
   function automatic logic [10:0] exp_frame(input logic [7:0] d, input int nbits,
                                             input int par, input bit odd,
                                             output int nb);
      logic [10:0] v;
      logic        p;
      v = '0;
      p = odd;
      for (int i = 0; i < nbits; i++) begin
         v[1+i] = d[i];
         p = p ^ d[i];
      end
      nb = 1 + nbits;
      if (par == 0) begin v[nb] = p;   nb++; end
      if (par == 1) begin v[nb] = odd; nb++; end
      return v;
   endfunction

   function automatic int exp_stop(input int code, input int nbits);
      if (code >= 8) return 17 + code;
      return 9 + code + ((nbits == 5) ? 8 : 0);
   endfunction

   task automatic capture(input int a, input int nb, output logic [10:0] v);
      v = '0;
      for (int k = 0; k < nb; k++) begin
         while (tcount < a + 16 * k + 8) step();
         v[k] = txd;
      end
   endtask

   // Two characters back to back: both frames and the start-to-start distance.
   task automatic run_pair(input int bits, input int par, input bit odd, input int code,
                           input logic [7:0] d1, input logic [7:0] d2, input string req);
      int a, b, nb, nbits;
      logic [10:0] e1, e2, c1, c2, m;
      nbits = 5 + bits;
      cfg_bits = 2'(bits); cfg_par = 2'(par); cfg_odd = odd; cfg_stop = 4'(code);
      e1 = exp_frame(d1, nbits, par, odd, nb);
      e2 = exp_frame(d2, nbits, par, odd, nb);
      m  = 11'((1 << nb) - 1);
      write_char(d1);
      wait_fall(a);
      write_char(d2);
      capture(a, nb, c1);
      chk((c1 & m) == (e1 & m), req, c1 & m, e1 & m);
      while (tcount < a + 16 * nb) step();
      wait_fall(b);
      chk((b - a) == 16 * nb + exp_stop(code, nbits), "R4 start-to-start ticks",
          b - a, 16 * nb + exp_stop(code, nbits));
      capture(b, nb, c2);
      chk((c2 & m) == (e2 & m), req, c2 & m, e2 & m);
      wait_empty();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      int a, b, c, nb;
      logic [10:0] v, e;

      // R1 reset state
      repeat (3) step();
      chk(txd === 1'b1,   "R1 reset txd",    txd, 1);
      chk(tx_emt === 1'b1,"R1 reset tx_emt", tx_emt, 1);
      chk(rts === 1'b0,   "R1 reset rts",    rts, 0);
      chk(tx_rdy === 1'b0,"R1 reset tx_rdy disabled", tx_rdy, 0);
      rst_n = 1'b1;
      step();

      // R10 disabled: write ignored
      write_char(8'h3C);
      tx_en = 1'b1;
      step();
      chk(tx_emt === 1'b1, "R10 write ignored while disabled", tx_emt, 1);
      chk(tx_rdy === 1'b1, "R5 ready when enabled and empty", tx_rdy, 1);
      wait_ticks(40);
      chk(txd === 1'b1, "R1 idle line mark", txd, 1);

      // R5 holding stage fill
      cfg_bits = 2'd3; cfg_par = 2'd2; cfg_stop = 4'hF;
      write_char(8'h81);
      chk(tx_rdy === 1'b0, "R5 tx_rdy low after write", tx_rdy, 0);
      wait_fall(a);
      write_char(8'h42);
      chk(tx_rdy === 1'b0 && tx_emt === 1'b0, "R5 held second char", {tx_rdy, tx_emt}, 0);
      write_char(8'hFF);
      wait_empty();

      // R2/R3 sweep of length, parity mode and sense
      for (int bits = 0; bits < 4; bits++)
         for (int par = 0; par < 3; par++)
            for (int odd = 0; odd < 2; odd++) begin
               logic [7:0] d;
               d = 8'h5A + 8'((bits * 6 + par * 2 + odd) * 29);
               run_pair(bits, par, odd[0], 15, d, ~d, "R2 R3 frame bits");
            end

      // R4 stop code sweep at 5 and 8 bits
      for (int code = 0; code < 16; code++) begin
         run_pair(0, 2, 1'b1, code, 8'h15, 8'h0A, "R4 frame bits 5-bit");
         run_pair(3, 2, 1'b0, code, 8'hC3, 8'h3C, "R4 frame bits 8-bit");
      end

      // R10 held character waits while disabled
      cfg_bits = 2'd3; cfg_par = 2'd2; cfg_stop = 4'hF;
      write_char(8'hA6);
      tx_en = 1'b0;
      wait_ticks(50);
      chk(txd === 1'b1 && tx_emt === 1'b0, "R10 no start while disabled", {txd, tx_emt}, 2'b10);
      tx_en = 1'b1;
      wait_fall(a);
      e = exp_frame(8'hA6, 8, 2, 1'b0, nb);
      capture(a, nb, v);
      chk(v[8:0] == e[8:0], "R10 frame after re-enable", v[8:0], e[8:0]);
      wait_empty();

      // R6 clear-to-send
      cfg_cts_en = 1'b1;
      cts = 1'b1;
      write_char(8'h99);
      wait_ticks(100);
      chk(txd === 1'b1 && tx_emt === 1'b0, "R6 held while cts high", {txd, tx_emt}, 2'b10);
      cts = 1'b0;
      wait_fall(a);
      e = exp_frame(8'h99, 8, 2, 1'b0, nb);
      capture(a, nb, v);
      chk(v[8:0] == e[8:0], "R6 frame after cts low", v[8:0], e[8:0]);
      wait_empty();
      write_char(8'h1E);
      wait_fall(a);
      cts = 1'b1;
      write_char(8'hE1);
      e = exp_frame(8'h1E, 8, 2, 1'b0, nb);
      capture(a, nb, v);
      chk(v[8:0] == e[8:0], "R6 current char completes", v[8:0], e[8:0]);
      while (tcount < a + 16 * nb + 32 + 40) step();
      chk(txd === 1'b1 && tx_emt === 1'b0, "R6 next char held", {txd, tx_emt}, 2'b10);
      cts = 1'b0;
      wait_fall(a);
      e = exp_frame(8'hE1, 8, 2, 1'b0, nb);
      capture(a, nb, v);
      chk(v[8:0] == e[8:0], "R6 held char sent", v[8:0], e[8:0]);
      wait_empty();
      cfg_cts_en = 1'b0;

      // R7 break from idle, R8 mark after stop-break
      brk_start = 1'b1; step(); brk_start = 1'b0;
      wait_ticks(2);
      chk(txd === 1'b0, "R7 break from idle", txd, 0);
      write_char(8'h55);
      wait_ticks(40);
      chk(txd === 1'b0 && tx_emt === 1'b0, "R7 break holds char", {txd, tx_emt}, 0);
      brk_stop = 1'b1; step(); brk_stop = 1'b0;
      c = tcount;
      while (txd !== 1'b1) step();
      while (txd !== 1'b0) step();
      b = tcount;
      chk((b - c) >= 16, "R8 mark before next start", b - c, 16);
      e = exp_frame(8'h55, 8, 2, 1'b0, nb);
      capture(b, nb, v);
      chk(v[8:0] == e[8:0], "R8 frame after break", v[8:0], e[8:0]);
      wait_empty();

      // R7 break requested during a character
      write_char(8'h0F);
      wait_fall(a);
      brk_start = 1'b1; step(); brk_start = 1'b0;
      e = exp_frame(8'h0F, 8, 2, 1'b0, nb);
      capture(a, nb, v);
      chk(v[8:0] == e[8:0], "R7 char completes before break", v[8:0], e[8:0]);
      while (tcount < a + 16 * nb + 16) step();
      chk(txd === 1'b1, "R7 stop bit kept before break", txd, 1);
      while (tcount < a + 16 * nb + 32 + 4) step();
      chk(txd === 1'b0, "R7 break after char", txd, 0);
      brk_stop = 1'b1; step(); brk_stop = 1'b0;
      wait_ticks(20);
      wait_empty();

      // R9 request-to-send
      rts_set = 1'b1; step(); rts_set = 1'b0;
      wait_ticks(40);
      chk(rts === 1'b1, "R9 rts stays without auto", rts, 1);
      rts_clr = 1'b1; step(); rts_clr = 1'b0;
      chk(rts === 1'b0, "R9 rts cleared", rts, 0);
      cfg_rts_auto = 1'b1;
      write_char(8'h77);
      rts_set = 1'b1; step(); rts_set = 1'b0;
      wait_fall(a);
      wait_ticks(20);
      chk(rts === 1'b1, "R9 rts held while sending", rts, 1);
      wait_empty();
      b = tcount;
      while (tcount < b + 15) step();
      chk(rts === 1'b1, "R9 rts before one bit time", rts, 1);
      while (tcount < b + 16) step();
      chk(rts === 1'b0, "R9 rts dropped after one bit time", rts, 0);
      cfg_rts_auto = 1'b0;

      finish_run();
   end

endmodule